// File: doc/BRIEF.md
# Three-Channel Compare Timer

This block is an up-counting timer with a small word-addressed register file. A clock-select field picks one of several single-cycle enable strobes (`src_tick`), a 12-bit divider stretches that strobe by (divider + 1), and each divided strobe moves the counter up by one. Three compare registers set status flags when the counter reaches their value. A rollover flag is set when the counter goes from its maximum value to zero. Status bits are cleared by writing ones. A single level interrupt combines status, per-flag enables and the timer enable.

The counter runs in one of two modes. In restart mode it returns to zero on the tick after it equals compare channel 1. In free-run mode it counts through its maximum and wraps. Software can restart the count in three ways: by enabling the timer with the enable-mode bit set, by writing compare channel 1 while in restart mode, or by a software reset. A software reset keeps the enable and clock-select related control bits and returns every other register to its power-on value. The capture registers are read-only and read as zero.

Top module: `cmp_timer`

## Requirements
- R1: Word addresses: 0 control, 1 divider, 2 status, 3 flag enable, 4/5/6 compare 1/2/3, 7/8 capture (read zero), 9 live counter (read-only). Writes to 7, 8 and 9 are ignored. Any other address reads zero and a write to it changes nothing. The divider keeps 12 bits.
- R2: After `rst`, the control, divider, status, flag-enable and counter registers read 0, and all three compare registers read all ones (counter maximum).
- R3: Control bits 2, 4 and 10..14 always read 0. The software-reset bit 15 reads 0. Bits 0, 1, 3, 5, 6..9 and 16..31 read back as written.
- R4: Clock-select field control[8:6]: code 0 gives no strobe. Code c selects `src_tick[c-1]`. An unselected strobe never moves the counter.
- R5: With enable (control bit 0) set, the counter advances by one on every (divider + 1)-th selected strobe.
- R6: Status bits: 0..2 compare 1..3, 3..4 capture (always 0), 5 rollover. Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: `irq` is high exactly when (status AND flag-enable) is nonzero and the enable bit is set. It follows a register write in the cycle after the write.
- R8: In restart mode (control bit 9 clear), the counter goes to 0 on the tick after it equals compare 1. A compare flag sets on the tick where the counter takes that compare's value.
- R9: In free-run mode (control bit 9 set), the counter wraps from its maximum to 0 and sets the rollover flag (status bit 5).
- R10: A write to compare 1 in restart mode forces the counter to 0. In free-run mode the same write leaves the counter unchanged.
- R11: When enable rises while the enable-mode bit (control bit 1) is set in the written value, the counter restarts from 0. Clearing enable holds the count. Re-enabling without enable-mode resumes from the held value.
- R12: Writing control with bit 15 set stores only bits 0, 1, 3, 5 and 8:6 of the written value. It returns the divider, status, flag-enable and counter to 0 and the compares to all ones, and it drops `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Word address for the read mux and for writes |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the address presented in the previous cycle |
| src_tick | input | NSRC | Candidate count strobes, selected by the clock-select field |
| irq | output | 1 | Level interrupt, registered |

## Verification
On every cycle, the bound checker confirms four things: the interrupt level matches the status, enable and run bits; reserved control bits and capture status bits stay zero; the counter holds while disabled or with no source selected; and each tick either adds one or performs the restart or rollover the mode requires. Some behaviour depends on long sequences and on exact values, so only the directed scenarios show it: divider ratios, restart period values, the flag pattern after a full free-run wrap, write-one-to-clear of status, and which control bits survive a soft reset.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int NCMP   = 3;
  localparam int ST_W   = 6;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP1 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP2 = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMP3 = 4'd6;
  localparam logic [ADDR_W-1:0] A_CAP1 = 4'd7;
  localparam logic [ADDR_W-1:0] A_CAP2 = 4'd8;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd9;

  localparam int B_RUN    = 0;
  localparam int B_ZSTART = 1;
  localparam int B_SEL_LO = 6;
  localparam int B_FREE   = 9;
  localparam int B_SWRST  = 15;
  localparam int SEL_W    = 3;

  // stored control bits, and those surviving a software reset
  localparam logic [DATA_W-1:0] CTRL_STORE = 32'hFFFF_03EB;
  localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h0000_01EB;

  localparam int ST_ROLL = 5;
endpackage

// File: rtl/cmp_timer_tick.sv
module cmp_timer_tick #(
  parameter int NSRC  = 7,
  parameter int SEL_W = 3,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [DIV_W-1:0] div,
  input  logic [NSRC-1:0]  src_tick,
  output logic             tick
);
  logic             picked;
  logic             adv;
  logic [DIV_W-1:0] phase_q;

  always_comb begin
    picked = 1'b0;
    for (int i = 1; i <= NSRC; i++) begin
      if (sel == SEL_W'(i)) picked = src_tick[i-1];
    end
  end

  assign adv  = run && picked;
  assign tick = adv && (phase_q >= div);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      phase_q <= '0;
    end else if (adv) begin
      phase_q <= (phase_q >= div) ? '0 : phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/cmp_timer_count.sv
module cmp_timer_count #(
  parameter int CNT_W = 32,
  parameter int NCMP  = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       tick,
  input  logic                       free_run,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp,
  output logic [CNT_W-1:0]           cnt,
  output logic [NCMP-1:0]            cmp_hit,
  output logic                       wrap
);
  logic             step;
  logic             restart_hit;
  logic [CNT_W-1:0] nxt;

  assign step        = tick && !clear;
  assign restart_hit = !free_run && (cnt == cmp[0]);
  assign nxt         = restart_hit ? '0 : cnt + 1'b1;
  assign wrap        = step && (&cnt);

  for (genvar g = 0; g < NCMP; g++) begin : g_hit
    assign cmp_hit[g] = step && (nxt == cmp[g]);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= nxt;
    end
  end
endmodule

// File: rtl/cmp_timer_status.sv
module cmp_timer_status #(
  parameter int ST_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            wr,
  input  logic [ST_W-1:0] wmask,
  input  logic [ST_W-1:0] set,
  input  logic [ST_W-1:0] ien_nxt,
  input  logic            run_nxt,
  output logic [ST_W-1:0] stat,
  output logic            irq
);
  logic [ST_W-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat;
    if (wr) stat_nxt = stat_nxt & ~wmask;
    stat_nxt = stat_nxt | set;
    if (clear) stat_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      stat <= stat_nxt;
      irq  <= (|(stat_nxt & ien_nxt)) && run_nxt;
    end
  end
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DIV_W = 12,
  parameter int NSRC  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NSRC-1:0]   src_tick,
  output logic              irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [DATA_W-1:0]          ctrl_q, ctrl_n;
  logic [DIV_W-1:0]           div_q, div_n;
  logic [ST_W-1:0]            ien_q, ien_n;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q, cmp_n;

  logic             wr_ctrl, sw_rst, run_rise, cmp1_restart, cnt_clear;
  logic             tick_w, wrap_w;
  logic [CNT_W-1:0] cnt_w;
  logic [NCMP-1:0]  hit_w;
  logic [ST_W-1:0]  stat_w, stat_set;
  logic [DATA_W-1:0] rd_n;

  assign wr_ctrl      = reg_we && (reg_addr == A_CTRL);
  assign sw_rst       = wr_ctrl && reg_wdata[B_SWRST];
  assign run_rise     = wr_ctrl && !sw_rst && reg_wdata[B_RUN] &&
                        !ctrl_q[B_RUN] && reg_wdata[B_ZSTART];
  assign cmp1_restart = reg_we && (reg_addr == A_CMP1) && !ctrl_q[B_FREE];
  assign cnt_clear    = sw_rst || run_rise || cmp1_restart;

  always_comb begin
    ctrl_n = ctrl_q;
    div_n  = div_q;
    ien_n  = ien_q;
    cmp_n  = cmp_q;
    if (sw_rst) begin
      ctrl_n = reg_wdata & CTRL_KEEP;
      div_n  = '0;
      ien_n  = '0;
      for (int i = 0; i < NCMP; i++) cmp_n[i] = CNT_MAX;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:  ctrl_n = reg_wdata & CTRL_STORE;
        A_DIV:   div_n  = reg_wdata[DIV_W-1:0];
        A_IEN:   ien_n  = reg_wdata[ST_W-1:0];
        A_CMP1:  cmp_n[0] = reg_wdata[CNT_W-1:0];
        A_CMP2:  cmp_n[1] = reg_wdata[CNT_W-1:0];
        A_CMP3:  cmp_n[2] = reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= '0;
      ien_q  <= '0;
      for (int i = 0; i < NCMP; i++) cmp_q[i] <= CNT_MAX;
    end else begin
      ctrl_q <= ctrl_n;
      div_q  <= div_n;
      ien_q  <= ien_n;
      cmp_q  <= cmp_n;
    end
  end

  cmp_timer_tick #(.NSRC(NSRC), .SEL_W(SEL_W), .DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst      (rst),
    .clear    (cnt_clear),
    .run      (ctrl_q[B_RUN]),
    .sel      (ctrl_q[B_SEL_LO +: SEL_W]),
    .div      (div_q),
    .src_tick (src_tick),
    .tick     (tick_w)
  );

  cmp_timer_count #(.CNT_W(CNT_W), .NCMP(NCMP)) u_count (
    .clk      (clk),
    .rst      (rst),
    .clear    (cnt_clear),
    .tick     (tick_w),
    .free_run (ctrl_q[B_FREE]),
    .cmp      (cmp_q),
    .cnt      (cnt_w),
    .cmp_hit  (hit_w),
    .wrap     (wrap_w)
  );

  always_comb begin
    stat_set = '0;
    stat_set[NCMP-1:0] = hit_w;
    stat_set[ST_ROLL]  = wrap_w;
  end

  cmp_timer_status #(.ST_W(ST_W)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .clear   (sw_rst),
    .wr      (reg_we && (reg_addr == A_STAT)),
    .wmask   (reg_wdata[ST_W-1:0]),
    .set     (stat_set),
    .ien_nxt (ien_n),
    .run_nxt (ctrl_n[B_RUN]),
    .stat    (stat_w),
    .irq     (irq)
  );

  always_comb begin
    case (reg_addr)
      A_CTRL:  rd_n = ctrl_q;
      A_DIV:   rd_n = DATA_W'(div_q);
      A_STAT:  rd_n = DATA_W'(stat_w);
      A_IEN:   rd_n = DATA_W'(ien_q);
      A_CMP1:  rd_n = DATA_W'(cmp_q[0]);
      A_CMP2:  rd_n = DATA_W'(cmp_q[1]);
      A_CMP3:  rd_n = DATA_W'(cmp_q[2]);
      A_CNT:   rd_n = DATA_W'(cnt_w);
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_n;
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_we,
  input logic [31:0]      ctrl,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp1,
  input logic [5:0]       stat,
  input logic [5:0]       ien,
  input logic             irq,
  input logic             tick
);
  p_irq_level_r7: assert property (@(posedge clk) disable iff (rst)
    irq == ((|(stat & ien)) && ctrl[0]));

  p_ctrl_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl[2] == 1'b0) && (ctrl[4] == 1'b0) && (ctrl[15:10] == 6'd0));

  p_cap_flags_zero_r6: assert property (@(posedge clk) disable iff (rst)
    stat[4:3] == 2'b00);

  p_hold_when_off_r11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl[0] && !reg_we) |=> $stable(cnt));

  p_no_source_r4: assert property (@(posedge clk) disable iff (rst)
    (ctrl[8:6] == 3'd0 && !reg_we) |=> $stable(cnt));

  p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && !reg_we && (ctrl[9] || cnt != cmp1)) |=> cnt == $past(cnt) + 1'b1);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    (tick && !reg_we && !ctrl[9] && cnt == cmp1) |=> cnt == '0);

  p_rollover_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && !reg_we && (&cnt)) |=> stat[5]);
endmodule

bind cmp_timer cmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .reg_we (reg_we),
  .ctrl   (ctrl_q),
  .cnt    (cnt_w),
  .cmp1   (cmp_q[0]),
  .stat   (stat_w),
  .ien    (ien_q),
  .irq    (irq),
  .tick   (tick_w)
);

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  src_tick = '0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cmp_timer #(.CNT_W(8), .DIV_W(12), .NSRC(7)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick), .irq(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R2 irq", {31'd0, irq}, 32'd0);
    rd_chk("R2 ctrl", 4'd0, 32'h0);
    rd_chk("R2 div", 4'd1, 32'h0);
    rd_chk("R2 stat", 4'd2, 32'h0);
    rd_chk("R2 ien", 4'd3, 32'h0);
    rd_chk("R2 cmp1", 4'd4, 32'hFF);
    rd_chk("R2 cmp2", 4'd5, 32'hFF);
    rd_chk("R2 cmp3", 4'd6, 32'hFF);
    rd_chk("R2 cnt", 4'd9, 32'h0);
  endtask

  task automatic t_regmap();
    wr(4'd0, 32'h0000_7C14);
    rd_chk("R3 reserved", 4'd0, 32'h0);
    wr(4'd0, 32'hABCD_0000);
    rd_chk("R3 upper bits", 4'd0, 32'hABCD_0000);
    wr(4'd0, 32'h0);
    wr(4'd1, 32'hFFFF_FFFF);
    rd_chk("R1 div 12 bits", 4'd1, 32'h0000_0FFF);
    wr(4'd1, 32'h0);
    wr(4'd10, 32'h123);
    rd_chk("R1 unmapped", 4'd10, 32'h0);
    wr(4'd7, 32'h55);
    rd_chk("R1 cap1", 4'd7, 32'h0);
    rd_chk("R1 cap2", 4'd8, 32'h0);
    wr(4'd9, 32'h55);
    rd_chk("R1 cnt ro", 4'd9, 32'h0);
    rd_chk("R1 cmp1 kept", 4'd4, 32'hFF);
  endtask

  task automatic t_nosrc();
    src_tick = 7'h7F;
    wr(4'd0, 32'h1);
    idle(20);
    rd_chk("R4 sel 0", 4'd9, 32'h0);
    wr(4'd0, 32'h0);
    src_tick = 7'b000_0001;
    wr(4'd0, 32'h81);
    idle(20);
    rd_chk("R4 sel 2 idle", 4'd9, 32'h0);
    wr(4'd0, 32'h80);
  endtask

  task automatic t_divide();
    src_tick = 7'b000_0001;
    wr(4'd1, 32'd3);
    wr(4'd0, 32'h41);
    idle(39);
    wr(4'd0, 32'h40);
    rd_chk("R5 div 4", 4'd9, 32'd10);
    idle(10);
    rd_chk("R11 hold", 4'd9, 32'd10);
    wr(4'd0, 32'h41);
    idle(3);
    wr(4'd0, 32'h40);
    rd_chk("R11 resume", 4'd9, 32'd11);
    wr(4'd1, 32'hFFF);
    wr(4'd0, 32'h43);
    rd_chk("R11 zero start", 4'd9, 32'd0);
    wr(4'd0, 32'h42);
  endtask

  task automatic t_restart();
    wr(4'd1, 32'd0);
    wr(4'd4, 32'd5);
    wr(4'd2, 32'h3F);
    wr(4'd0, 32'h43);
    idle(19);
    wr(4'd0, 32'h42);
    rd_chk("R8 period", 4'd9, 32'd2);
    rd_chk("R8 flag", 4'd2, 32'h01);
    wr(4'd4, 32'd5);
    rd_chk("R10 restart write", 4'd9, 32'd0);
  endtask

  task automatic t_irq();
    src_tick = '0;
    wr(4'd2, 32'h0);
    rd_chk("R6 write 0", 4'd2, 32'h01);
    wr(4'd3, 32'h01);
    check("R7 off", {31'd0, irq}, 32'd0);
    wr(4'd0, 32'h41);
    check("R7 on", {31'd0, irq}, 32'd1);
    wr(4'd3, 32'h00);
    check("R7 masked", {31'd0, irq}, 32'd0);
    wr(4'd3, 32'h01);
    check("R7 unmasked", {31'd0, irq}, 32'd1);
    wr(4'd2, 32'h01);
    check("R7 cleared", {31'd0, irq}, 32'd0);
    rd_chk("R6 w1c", 4'd2, 32'h0);
    wr(4'd0, 32'h40);
    wr(4'd3, 32'h0);
  endtask

  task automatic t_freerun();
    src_tick = 7'b000_0001;
    wr(4'd5, 32'd100);
    wr(4'd0, 32'h240);
    wr(4'd2, 32'h3F);
    wr(4'd0, 32'h243);
    idle(259);
    wr(4'd0, 32'h240);
    rd_chk("R9 wrap count", 4'd9, 32'd4);
    rd_chk("R9 flags", 4'd2, 32'h27);
    wr(4'd4, 32'd9);
    rd_chk("R10 free run write", 4'd9, 32'd4);
  endtask

  task automatic t_softrst();
    src_tick = '0;
    wr(4'd1, 32'd7);
    wr(4'd3, 32'h21);
    wr(4'd0, 32'h0001_02E9);
    rd_chk("R12 pre ctrl", 4'd0, 32'h0001_02E9);
    rd_chk("R12 pre cnt", 4'd9, 32'd4);
    check("R12 pre irq", {31'd0, irq}, 32'd1);
    wr(4'd0, 32'h0001_82E9);
    check("R12 irq", {31'd0, irq}, 32'd0);
    rd_chk("R12 ctrl kept", 4'd0, 32'h0000_00E9);
    rd_chk("R12 div", 4'd1, 32'h0);
    rd_chk("R12 stat", 4'd2, 32'h0);
    rd_chk("R12 ien", 4'd3, 32'h0);
    rd_chk("R12 cmp1", 4'd4, 32'hFF);
    rd_chk("R12 cmp2", 4'd5, 32'hFF);
    rd_chk("R12 cnt", 4'd9, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_nosrc();
    t_divide();
    t_restart();
    t_irq();
    t_freerun();
    t_softrst();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule